// File: doc/BRIEF.md
# Sliding-Window Register File

This block is a floating-point register file with 128 physical entries. Arithmetic instructions see only 32 logical registers. Logical registers 0 to 7 are global and are the same for every window. Logical registers 8 to 31 are local and fall into a 120-entry circular region. A window-base pointer chooses where the local part lands in that region. A set command moves the pointer by any amount, so the visible window can slide by one register or jump to a region that is far away.

Arithmetic has two read ports and one write port, and all three take logical register numbers. A separate memory-side port addresses the local region as an offset from the current pointer. Its write half, the preload, fills registers that later windows will expose. Its read half, the poststore, drains registers that earlier windows computed. Memory traffic can therefore run ahead of or behind the window the arithmetic is using.

Reads are combinational and forward a write made in the same cycle. When an arithmetic write and a preload write target one physical register in the same cycle, the arithmetic write is stored, the preload is dropped, and a conflict flag goes high for that cycle.

Top module: `slidewin_regfile`

## Requirements
- R1: After reset every physical register reads zero and the window pointer is zero.
- R2: Logical registers 0..7 reach physical registers 0..7 whatever the pointer holds.
- R3: A logical register L in 8..31 reaches physical register 8 + ((P + L - 8) mod 120), where P is the pointer.
- R4: When `ptr_set` is high at a clock edge, the pointer takes `ptr_val`, and reads take the new pointer from the next cycle on. In the cycle of the set command, reads still use the old pointer. Without `ptr_set` the pointer keeps its value.
- R5: A preload with offset O writes `pl_data` into physical register 8 + ((P + O) mod 120).
- R6: A poststore with offset O returns the contents of physical register 8 + ((P + O) mod 120).
- R7: When an arithmetic write and a preload target the same physical register in one cycle, `conflict` is high in that cycle, the arithmetic data is stored and the preload is discarded. In all other cycles `conflict` is low.
- R8: A read on any port that selects a physical register being written in the same cycle returns the data being written.
- R9: The two arithmetic read ports decode their indices independently and may select different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_set | input | 1 | Load the window pointer |
| ptr_val | input | 7 | New pointer value, 0..119 |
| rd_a_idx | input | 5 | Logical index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 5 | Logical index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Arithmetic write enable |
| wr_idx | input | 5 | Logical index for the arithmetic write |
| wr_data | input | 32 | Arithmetic write data |
| pl_en | input | 1 | Preload write enable |
| pl_off | input | 7 | Pointer-relative preload offset, 0..119 |
| pl_data | input | 32 | Preload data |
| ps_off | input | 7 | Pointer-relative poststore offset, 0..119 |
| ps_data | output | 32 | Poststore data |
| conflict | output | 1 | Arithmetic write and preload collided this cycle |

## Verification
The assertions assume that `ptr_val`, `pl_off` and `ps_off` always stay below 120. Values outside that range are not defined for this block. The pointer-range check relies on this assumption. The bench drives only in-range values: pointers from a fixed list that includes 0, 1, 119 and values near the wrap, and offsets swept over 0..119. The conflict and wrap cases are built so that a logical index and a preload offset meet on the same physical register across the modulo boundary.

// File: rtl/swrf_pkg.sv
package swrf_pkg;
  // Slot in the circular local region: first local entry plus wrapped distance.
  function automatic int unsigned local_slot(int unsigned base, int unsigned rel,
                                             int unsigned nglob, int unsigned nloc);
    return nglob + ((base + rel) % nloc);
  endfunction
endpackage

// File: rtl/swrf_ptr_reg.sv
module swrf_ptr_reg #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [PW-1:0] val,
  output logic [PW-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (set) ptr_q <= val;
  end
endmodule

// File: rtl/swrf_addr_map.sv
module swrf_addr_map #(
  parameter int NGLOB       = 8,
  parameter int NLOC        = 120,
  parameter int PW          = 7,
  parameter int IW          = 5,
  parameter int PHW         = 7,
  parameter bit OFFSET_MODE = 1'b0
) (
  input  logic [PW-1:0]  ptr,
  input  logic [IW-1:0]  idx,
  output logic [PHW-1:0] phys
);
  generate
    if (OFFSET_MODE) begin : g_offset
      // Memory side: index is already an offset into the local region.
      always_comb
        phys = PHW'(swrf_pkg::local_slot(32'(ptr), 32'(idx), NGLOB, NLOC));
    end else begin : g_logical
      // Arithmetic side: globals pass through, locals slide with the pointer.
      always_comb begin
        if (32'(idx) < NGLOB) phys = PHW'(idx);
        else phys = PHW'(swrf_pkg::local_slot(32'(ptr), 32'(idx) - NGLOB, NGLOB, NLOC));
      end
    end
  endgenerate
endmodule

// File: rtl/swrf_storage.sv
module swrf_storage #(
  parameter int NPHYS = 128,
  parameter int DW    = 32,
  parameter int NRD   = 3,
  localparam int PHW  = $clog2(NPHYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wa_en,
  input  logic [PHW-1:0]           wa_phys,
  input  logic [DW-1:0]            wa_data,
  input  logic                     wb_en,
  input  logic [PHW-1:0]           wb_phys,
  input  logic [DW-1:0]            wb_data,
  input  logic [NRD-1:0][PHW-1:0]  rd_phys,
  output logic [NRD-1:0][DW-1:0]   rd_data,
  output logic                     collide,
  output logic                     wb_commit
);
  logic [DW-1:0] mem [NPHYS];

  // Port A (arithmetic) has priority over port B (preload).
  assign collide   = wa_en && wb_en && (wa_phys == wb_phys);
  assign wb_commit = wb_en && !collide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else begin
      if (wb_commit) mem[wb_phys] <= wb_data;
      if (wa_en)     mem[wa_phys] <= wa_data;
    end
  end

  generate
    for (genvar r = 0; r < NRD; r++) begin : g_rd
      always_comb begin
        if (wa_en && wa_phys == rd_phys[r])          rd_data[r] = wa_data;
        else if (wb_commit && wb_phys == rd_phys[r]) rd_data[r] = wb_data;
        else                                         rd_data[r] = mem[rd_phys[r]];
      end
    end
  endgenerate
endmodule

// File: rtl/slidewin_regfile.sv
module slidewin_regfile #(
  parameter int NPHYS = 128,
  parameter int NLOG  = 32,
  parameter int NGLOB = 8,
  parameter int DW    = 32,
  localparam int NLOC = NPHYS - NGLOB,
  localparam int PHW  = $clog2(NPHYS),
  localparam int LW   = $clog2(NLOG),
  localparam int OW   = $clog2(NLOC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_set,
  input  logic [OW-1:0] ptr_val,
  input  logic [LW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [LW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          pl_en,
  input  logic [OW-1:0] pl_off,
  input  logic [DW-1:0] pl_data,
  input  logic [OW-1:0] ps_off,
  output logic [DW-1:0] ps_data,
  output logic          conflict
);
  // Named internal events, visible to the bound checker.
  logic [OW-1:0]           ptr_q;
  logic [PHW-1:0]          a_phys, b_phys, wr_phys, pl_phys, ps_phys;
  logic                    pl_commit;
  logic [2:0][PHW-1:0]     rd_phys;
  logic [2:0][DW-1:0]      rd_data;

  swrf_ptr_reg #(.PW(OW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .set(ptr_set), .val(ptr_val), .ptr_q(ptr_q)
  );

  swrf_addr_map #(.NGLOB(NGLOB), .NLOC(NLOC), .PW(OW), .IW(LW), .PHW(PHW), .OFFSET_MODE(1'b0))
    u_map_a  (.ptr(ptr_q), .idx(rd_a_idx), .phys(a_phys));
  swrf_addr_map #(.NGLOB(NGLOB), .NLOC(NLOC), .PW(OW), .IW(LW), .PHW(PHW), .OFFSET_MODE(1'b0))
    u_map_b  (.ptr(ptr_q), .idx(rd_b_idx), .phys(b_phys));
  swrf_addr_map #(.NGLOB(NGLOB), .NLOC(NLOC), .PW(OW), .IW(LW), .PHW(PHW), .OFFSET_MODE(1'b0))
    u_map_w  (.ptr(ptr_q), .idx(wr_idx), .phys(wr_phys));
  swrf_addr_map #(.NGLOB(NGLOB), .NLOC(NLOC), .PW(OW), .IW(OW), .PHW(PHW), .OFFSET_MODE(1'b1))
    u_map_pl (.ptr(ptr_q), .idx(pl_off), .phys(pl_phys));
  swrf_addr_map #(.NGLOB(NGLOB), .NLOC(NLOC), .PW(OW), .IW(OW), .PHW(PHW), .OFFSET_MODE(1'b1))
    u_map_ps (.ptr(ptr_q), .idx(ps_off), .phys(ps_phys));

  assign rd_phys = {ps_phys, b_phys, a_phys};

  swrf_storage #(.NPHYS(NPHYS), .DW(DW), .NRD(3)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wr_en), .wa_phys(wr_phys), .wa_data(wr_data),
    .wb_en(pl_en), .wb_phys(pl_phys), .wb_data(pl_data),
    .rd_phys(rd_phys), .rd_data(rd_data),
    .collide(conflict), .wb_commit(pl_commit)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];
  assign ps_data   = rd_data[2];
endmodule

// File: rtl/swrf_chk.sv
module swrf_chk #(
  parameter int NPHYS = 128,
  parameter int NGLOB = 8,
  parameter int LW    = 5,
  parameter int OW    = 7,
  parameter int PHW   = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ptr_set,
  input logic [OW-1:0]  ptr_val,
  input logic [OW-1:0]  ptr_q,
  input logic [LW-1:0]  rd_a_idx,
  input logic [PHW-1:0] a_phys,
  input logic           wr_en,
  input logic           pl_en,
  input logic           pl_commit,
  input logic           conflict
);
  localparam int NLOC = NPHYS - NGLOB;

  // R4
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_set |=> ptr_q == $past(ptr_val));
  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_set |=> $stable(ptr_q));
  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr_q) < NLOC);
  // R2
  glob_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_a_idx) < NGLOB) |-> (a_phys == PHW'(rd_a_idx)));
  // R3
  local_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_a_idx) >= NGLOB) |-> (32'(a_phys) >= NGLOB && 32'(a_phys) < NPHYS));
  // R7
  conflict_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (wr_en && pl_en && !pl_commit));
  // R5
  preload_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_en && !conflict) |-> pl_commit);
endmodule

bind slidewin_regfile swrf_chk #(
  .NPHYS(NPHYS), .NGLOB(NGLOB), .LW(LW), .OW(OW), .PHW(PHW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_set(ptr_set), .ptr_val(ptr_val),
  .ptr_q(ptr_q), .rd_a_idx(rd_a_idx), .a_phys(a_phys),
  .wr_en(wr_en), .pl_en(pl_en), .pl_commit(pl_commit), .conflict(conflict)
);

// File: tb/tb_slidewin_regfile.sv
`timescale 1ns/1ps
module tb_slidewin_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_set = 1'b0;
  logic [6:0]  ptr_val = '0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pl_data = '0, ps_data;
  logic        wr_en = 1'b0, pl_en = 1'b0, conflict;
  logic [6:0]  pl_off = '0, ps_off = '0;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  int unsigned cur_ptr = 0;
  logic [31:0] model [128];

  always #5 clk = ~clk;

  slidewin_regfile dut (
    .clk(clk), .rst_n(rst_n), .ptr_set(ptr_set), .ptr_val(ptr_val),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pl_en(pl_en), .pl_off(pl_off), .pl_data(pl_data),
    .ps_off(ps_off), .ps_data(ps_data), .conflict(conflict)
  );

  // Physical slot of a logical register under pointer p.
  function automatic int unsigned log2phys(int unsigned p, int unsigned l);
    if (l < 8) return l;
    return 8 + (p + l - 8) % 120;
  endfunction
  // Physical slot of a memory-side offset under pointer p.
  function automatic int unsigned off2phys(int unsigned p, int unsigned o);
    return 8 + (p + o) % 120;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sweep(int unsigned p);
    @(negedge clk);
    ptr_set = 1'b1; ptr_val = 7'(p);
    rd_a_idx = 5'd9;
    #1 chk("R4 old pointer in set cycle", rd_a_data, model[log2phys(cur_ptr, 9)]);
    @(negedge clk);
    ptr_set = 1'b0; cur_ptr = p;
    for (int l = 0; l < 32; l++) begin
      rd_a_idx = 5'(l); rd_b_idx = 5'(31 - l);
      #1;
      if (l < 8) chk("R2 global map", rd_a_data, model[log2phys(p, l)]);
      else       chk("R3 local map", rd_a_data, model[log2phys(p, l)]);
      chk("R9 port B", rd_b_data, model[log2phys(p, 31 - l)]);
    end
    for (int o = 0; o < 120; o++) begin
      ps_off = 7'(o);
      #1 chk("R6 poststore", ps_data, model[off2phys(p, o)]);
    end
  endtask

  task automatic preload_all(int unsigned seed);
    for (int o = 0; o < 120; o++) begin
      @(negedge clk);
      pl_en = 1'b1; pl_off = 7'(o); pl_data = 32'(seed * 32'h10000 + o * 3 + 1);
      model[off2phys(cur_ptr, o)] = pl_data;
    end
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: everything zero after reset, pointer at zero
    for (int l = 0; l < 32; l++) begin
      rd_a_idx = 5'(l); #1 chk("R1 reset logical", rd_a_data, 32'h0);
    end
    for (int o = 0; o < 120; o++) begin
      ps_off = 7'(o); #1 chk("R1 reset offset", ps_data, 32'h0);
    end
    chk("R7 conflict idle", {31'b0, conflict}, 32'h0);

    // Fill local region through preload at pointer 0, globals via arithmetic
    preload_all(1);
    for (int g = 0; g < 8; g++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'(g); wr_data = 32'hC0DE_0000 + 32'(g);
      model[g] = wr_data;
    end
    @(negedge clk);
    wr_en = 1'b0;
    for (int o = 0; o < 120; o++) begin
      ps_off = 7'(o); #1 chk("R5 preload at ptr 0", ps_data, model[off2phys(0, o)]);
    end

    sweep(0); sweep(1); sweep(7); sweep(60); sweep(112); sweep(119); sweep(113);

    // R5: preload at a nonzero pointer, seen through logical reads later
    sweep(50);
    preload_all(2);
    for (int l = 8; l < 32; l++) begin
      rd_a_idx = 5'(l);
      #1 chk("R5 preload at ptr 50", rd_a_data, model[log2phys(50, l)]);
    end
    sweep(30);

    // R8: bypass of arithmetic write and preload in the same cycle, no collision
    sweep(50);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'hAAAA_5555;
    pl_en = 1'b1; pl_off = 7'd100; pl_data = 32'h1234_5678;
    rd_a_idx = 5'd20; ps_off = 7'd100; rd_b_idx = 5'd3;
    #1;
    chk("R8 arith bypass", rd_a_data, 32'hAAAA_5555);
    chk("R8 preload bypass", ps_data, 32'h1234_5678);
    chk("R7 no conflict on distinct slots", {31'b0, conflict}, 32'h0);
    model[log2phys(50, 20)] = 32'hAAAA_5555;
    model[off2phys(50, 100)] = 32'h1234_5678;
    @(negedge clk);
    wr_en = 1'b0; pl_en = 1'b0;
    #1;
    chk("R8 arith stored", rd_a_data, 32'hAAAA_5555);
    chk("R8 preload stored", ps_data, 32'h1234_5678);

    // R7: collision at ptr 50, logical 8 and offset 0 both reach slot 58
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd8; wr_data = 32'hFEED_0001;
    pl_en = 1'b1; pl_off = 7'd0; pl_data = 32'hBAD0_0001;
    rd_a_idx = 5'd8; ps_off = 7'd0;
    #1;
    chk("R7 conflict raised", {31'b0, conflict}, 32'h1);
    chk("R7 arith wins bypass", ps_data, 32'hFEED_0001);
    model[58] = 32'hFEED_0001;
    @(negedge clk);
    wr_en = 1'b0; pl_en = 1'b0;
    #1;
    chk("R7 conflict clears", {31'b0, conflict}, 32'h0);
    chk("R7 arith stored", rd_a_data, 32'hFEED_0001);

    // R7: collision across the wrap, ptr 119: logical 9 and offset 1 both reach slot 8
    sweep(119);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'hFEED_0002;
    pl_en = 1'b1; pl_off = 7'd1; pl_data = 32'hBAD0_0002;
    #1 chk("R7 wrap conflict", {31'b0, conflict}, 32'h1);
    model[8] = 32'hFEED_0002;
    @(negedge clk);
    wr_en = 1'b0; pl_en = 1'b0;
    ps_off = 7'd1;
    #1 chk("R7 wrap arith stored", ps_data, 32'hFEED_0002);

    // R7: global write alongside a preload never collides
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'h0505_0505;
    pl_en = 1'b1; pl_off = 7'd5; pl_data = 32'h5050_5050;
    #1 chk("R7 global no conflict", {31'b0, conflict}, 32'h0);
    model[5] = 32'h0505_0505;
    model[off2phys(119, 5)] = 32'h5050_5050;
    @(negedge clk);
    wr_en = 1'b0; pl_en = 1'b0;
    sweep(119);
    sweep(0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule